// File: doc/BRIEF.md
# Ethernet Receive Frame Acceptance Filter

This block sits between a receive byte stream (one byte per cycle, preamble and start delimiter already removed) and the receive buffer. For each frame it decides whether to keep or drop it. It compares the destination address with a programmed station address, applies the multicast and promiscuous gates, and checks the frame check sequence with a running CRC-32. Accepted bytes are written into an internal byte FIFO. A rejected frame is removed by moving the write pointer back to where the frame started.

Software sees four 32-bit registers on a single-cycle bus, selected by a 2-bit word index. Index 0 is the control register, 1 and 2 hold the station address, and 3 is the status register. A consumer pops bytes from the FIFO. The FIFO only shows bytes of frames that have been fully received and accepted.

Top module: `rx_frame_filter`

## Requirements
- R1: Register map by word index: 0 = control (bit0 receive enable, bit1 multicast enable, bit2 promiscuous, bit3 reject-bad-CRC, bit4 FIFO flush); 1 = station address destination bytes 0..3 (bits 7:0 = byte 0, which arrives first); 2 = bytes 4..5 in bits 15:0; 3 = status with bit0 the receive-error flag. All bits reset to 0. Unused bits read 0. A write to index 0 is visible on the next read.
- R2: A frame whose first byte arrives while receive enable is 0 is ignored as a whole. Nothing is written, and a bad CRC in it does not raise the error flag.
- R3: With promiscuous and multicast off, a frame is kept only when all six destination bytes equal the station address bytes in arrival order.
- R4: A frame whose first destination byte has bit0 = 1 (multicast, including the all-ones broadcast address) is kept in non-promiscuous mode exactly when multicast enable is 1, whatever the station address.
- R5: With promiscuous set, a frame is kept whatever its destination address.
- R6: CRC-32 (reflected, polynomial 0x04C11DB7, initial all ones, FCS sent least significant byte first) is checked over the whole frame. With reject-bad-CRC set, a bad frame is dropped, the error flag is set and the whole FIFO is emptied, including earlier accepted frames. With it clear, a bad frame is kept and the flag is not touched.
- R7: The error flag, which also drives `rx_err_irq`, stays set until software writes 1 to status bit0. Writing 0 has no effect.
- R8: Writing 1 to control bit4 empties the FIFO at that clock edge. The bit then reads 1 until the control register is read once, and reads 0 after that.
- R9: A kept frame, FCS included, becomes readable in arrival order on the cycle after its last byte. Before that the FIFO looks empty. A dropped frame leaves the FIFO contents unchanged.
- R10: A frame that ends before its sixth byte is dropped. A frame that would overflow the FIFO is dropped, and the next frame is received normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 2 | Register word index |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (needed for the read-to-clear flush bit) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| rx_valid | input | 1 | Receive byte valid |
| rx_data | input | 8 | Receive byte |
| rx_last | input | 1 | Marks the final byte of a frame (last FCS byte) |
| fifo_rd | input | 1 | Pop one byte from the FIFO |
| fifo_data | output | 8 | Byte at the head of the FIFO |
| fifo_empty | output | 1 | No committed byte is available |
| rx_err_irq | output | 1 | Sticky receive-error flag |

## Verification
Register read data is combinational, so the bench samples it 1 ns after driving the address, inside the same cycle. A kept frame shows up at the FIFO head one cycle after the edge that takes its last byte. The error flag and the emptying caused by a bad CRC or a flush write take effect at that same edge, so the bench checks them at the next falling edge. A monitor process pops bytes at falling edges and compares them against a queue that the driver filled with the frames expected to be kept. After each frame the bench waits a fixed settling time and then requires the queue to be empty. This catches both lost bytes and extra bytes.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

    localparam int REG_AW = 2;
    localparam logic [REG_AW-1:0] RA_CTRL   = 2'd0;
    localparam logic [REG_AW-1:0] RA_STA_LO = 2'd1;
    localparam logic [REG_AW-1:0] RA_STA_HI = 2'd2;
    localparam logic [REG_AW-1:0] RA_STAT   = 2'd3;

    localparam int DA_BYTES = 6;
    localparam int CNT_W    = 3;

    localparam logic [31:0] CRC_POLY_R = 32'hEDB88320;
    localparam logic [31:0] CRC_INIT   = 32'hFFFFFFFF;
    localparam logic [31:0] CRC_GOOD   = 32'hDEBB20E3;

    // Bit order matches the control register layout (bit4 .. bit0).
    typedef struct packed {
        logic flush;
        logic rej_crc;
        logic promisc;
        logic mcast_en;
        logic rx_en;
    } rxf_ctrl_t;

    typedef struct packed {
        logic       push;
        logic       rollback;
        logic       commit;
        logic       clear;
        logic [7:0] data;
    } rxf_wcmd_t;

    function automatic logic [31:0] crc32_step(input logic [31:0] c, input logic [7:0] d);
        logic [31:0] r;
        r = c ^ {24'd0, d};
        for (int i = 0; i < 8; i++)
            r = r[0] ? ((r >> 1) ^ CRC_POLY_R) : (r >> 1);
        return r;
    endfunction

endpackage

// File: rtl/rxf_regs.sv
module rxf_regs
    import rxf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              err_set,
    output rxf_ctrl_t         ctrl,
    output logic [47:0]       station,
    output logic              err_flag,
    output logic              flush_pulse
);
    rxf_ctrl_t   ctrl_q;
    logic [47:0] sta_q;
    logic        err_q;

    logic wr_ctrl, rd_ctrl, wr_stat;
    assign wr_ctrl     = reg_wr && (reg_addr == RA_CTRL);
    assign rd_ctrl     = reg_rd && (reg_addr == RA_CTRL);
    assign wr_stat     = reg_wr && (reg_addr == RA_STAT);
    assign flush_pulse = wr_ctrl && reg_wdata[4];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            sta_q  <= '0;
            err_q  <= 1'b0;
        end else begin
            if (wr_ctrl) begin
                ctrl_q.rx_en    <= reg_wdata[0];
                ctrl_q.mcast_en <= reg_wdata[1];
                ctrl_q.promisc  <= reg_wdata[2];
                ctrl_q.rej_crc  <= reg_wdata[3];
            end
            ctrl_q.flush <= (ctrl_q.flush && !rd_ctrl) || flush_pulse;
            if (reg_wr && reg_addr == RA_STA_LO) sta_q[31:0]  <= reg_wdata;
            if (reg_wr && reg_addr == RA_STA_HI) sta_q[47:32] <= reg_wdata[15:0];
            err_q <= err_set || (err_q && !(wr_stat && reg_wdata[0]));
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            RA_CTRL:   reg_rdata[4:0]  = ctrl_q;
            RA_STA_LO: reg_rdata       = sta_q[31:0];
            RA_STA_HI: reg_rdata[15:0] = sta_q[47:32];
            RA_STAT:   reg_rdata[0]    = err_q;
            default:   reg_rdata       = '0;
        endcase
    end

    assign ctrl     = ctrl_q;
    assign station  = sta_q;
    assign err_flag = err_q;
endmodule

// File: rtl/rxf_crc32.sv
module rxf_crc32
    import rxf_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    input  logic        in_first,
    input  logic [7:0]  in_data,
    output logic        crc_ok
);
    logic [31:0] crc_q, base, nxt;

    assign base   = in_first ? CRC_INIT : crc_q;
    assign nxt    = crc32_step(base, in_data);
    assign crc_ok = (nxt == CRC_GOOD);

    always_ff @(posedge clk) begin
        if (rst)           crc_q <= CRC_INIT;
        else if (in_valid) crc_q <= nxt;
    end
endmodule

// File: rtl/rxf_buffer.sv
module rxf_buffer
    import rxf_pkg::*;
#(
    parameter int DEPTH = 64
) (
    input  logic      clk,
    input  logic      rst,
    input  rxf_wcmd_t cmd,
    input  logic      rd_en,
    output logic [7:0] rd_data,
    output logic      empty,
    output logic      full
);
    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;

    logic [7:0]    mem [DEPTH];
    logic [PW-1:0] wr_p, cm_p, rd_p, used;
    logic          pop, wr_mem;

    assign used    = wr_p - rd_p;
    assign full    = (used == PW'(DEPTH));
    assign empty   = (rd_p == cm_p);
    assign pop     = rd_en && !empty;
    assign wr_mem  = cmd.push && !cmd.rollback && !cmd.clear;
    assign rd_data = mem[rd_p[AW-1:0]];

    always_ff @(posedge clk) begin
        if (wr_mem) mem[wr_p[AW-1:0]] <= cmd.data;
    end

    always_ff @(posedge clk) begin
        if (rst || cmd.clear) begin
            wr_p <= '0;
            cm_p <= '0;
            rd_p <= '0;
        end else begin
            if (cmd.rollback)  wr_p <= cm_p;
            else if (cmd.push) wr_p <= wr_p + 1'b1;
            if (cmd.commit)    cm_p <= cmd.push ? wr_p + 1'b1 : wr_p;
            if (pop)           rd_p <= rd_p + 1'b1;
        end
    end
endmodule

// File: rtl/rxf_decide.sv
module rxf_decide
    import rxf_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        rx_valid,
    input  logic [7:0]  rx_data,
    input  logic        rx_last,
    input  rxf_ctrl_t   ctrl,
    input  logic [47:0] station,
    input  logic        flush,
    input  logic        fifo_full,
    output rxf_wcmd_t   cmd,
    output logic        err_set
);
    logic             in_frame, fr_en, keep, match_q, mcast_q;
    logic [CNT_W-1:0] cnt;

    logic             first, en_now, keep_now, match_now, mcast_now, addr_ok;
    logic             crc_ok, drop_addr, drop_runt, drop_ovf, bad_rej, drop;
    logic [CNT_W-1:0] idx;
    logic [7:0]       sta_byte;

    assign first    = rx_valid && !in_frame;
    assign idx      = first ? '0 : cnt;
    assign en_now   = first ? ctrl.rx_en : fr_en;
    assign keep_now = first ? ctrl.rx_en : keep;

    always_comb begin
        sta_byte = '0;
        for (int i = 0; i < DA_BYTES; i++)
            if (idx == CNT_W'(i)) sta_byte = station[8*i +: 8];
    end

    assign match_now = (first || match_q) && (rx_data == sta_byte);
    assign mcast_now = first ? rx_data[0] : mcast_q;
    assign addr_ok   = ctrl.promisc || (mcast_now ? ctrl.mcast_en : match_now);

    rxf_crc32 u_crc (
        .clk      (clk),
        .rst      (rst),
        .in_valid (rx_valid),
        .in_first (first),
        .in_data  (rx_data),
        .crc_ok   (crc_ok)
    );

    assign drop_addr = rx_valid && (idx == CNT_W'(DA_BYTES - 1)) && !addr_ok;
    assign drop_runt = rx_valid && rx_last && (idx < CNT_W'(DA_BYTES - 1));
    assign drop_ovf  = rx_valid && fifo_full;
    assign bad_rej   = rx_valid && rx_last && en_now && ctrl.rej_crc && !crc_ok;
    assign drop      = keep_now && (drop_addr || drop_runt || drop_ovf || bad_rej || flush);

    always_comb begin
        cmd.push     = rx_valid && keep_now && !drop;
        cmd.rollback = drop;
        cmd.commit   = rx_valid && rx_last && keep_now && !drop;
        cmd.clear    = flush || bad_rej;
        cmd.data     = rx_data;
    end
    assign err_set = bad_rej;

    always_ff @(posedge clk) begin
        if (rst) begin
            in_frame <= 1'b0;
            fr_en    <= 1'b0;
            keep     <= 1'b0;
            cnt      <= '0;
            match_q  <= 1'b0;
            mcast_q  <= 1'b0;
        end else begin
            if (rx_valid) begin
                in_frame <= !rx_last;
                fr_en    <= en_now;
                keep     <= keep_now && !drop;
                cnt      <= (idx == '1) ? idx : idx + 1'b1;
                match_q  <= match_now;
                mcast_q  <= mcast_now;
            end
            if (flush) keep <= 1'b0;
        end
    end
endmodule

// File: rtl/rx_frame_filter.sv
module rx_frame_filter
    import rxf_pkg::*;
#(
    parameter int FIFO_DEPTH = 64
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [1:0]  reg_addr,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        rx_valid,
    input  logic [7:0]  rx_data,
    input  logic        rx_last,
    input  logic        fifo_rd,
    output logic [7:0]  fifo_data,
    output logic        fifo_empty,
    output logic        rx_err_irq
);
    rxf_ctrl_t   w_ctrl;
    rxf_wcmd_t   w_cmd;
    logic [47:0] w_station;
    logic        w_err_set, w_flush, w_full;

    rxf_regs u_regs (
        .clk         (clk),
        .rst         (rst),
        .reg_addr    (reg_addr),
        .reg_wr      (reg_wr),
        .reg_rd      (reg_rd),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata),
        .err_set     (w_err_set),
        .ctrl        (w_ctrl),
        .station     (w_station),
        .err_flag    (rx_err_irq),
        .flush_pulse (w_flush)
    );

    rxf_decide u_dec (
        .clk       (clk),
        .rst       (rst),
        .rx_valid  (rx_valid),
        .rx_data   (rx_data),
        .rx_last   (rx_last),
        .ctrl      (w_ctrl),
        .station   (w_station),
        .flush     (w_flush),
        .fifo_full (w_full),
        .cmd       (w_cmd),
        .err_set   (w_err_set)
    );

    rxf_buffer #(.DEPTH(FIFO_DEPTH)) u_buf (
        .clk     (clk),
        .rst     (rst),
        .cmd     (w_cmd),
        .rd_en   (fifo_rd),
        .rd_data (fifo_data),
        .empty   (fifo_empty),
        .full    (w_full)
    );
endmodule

// File: rtl/rxf_checker.sv
module rxf_checker (
    input logic        clk,
    input logic        rst,
    input logic [1:0]  reg_addr,
    input logic        reg_wr,
    input logic        reg_rd,
    input logic [31:0] reg_wdata,
    input logic [31:0] reg_rdata,
    input logic        rx_valid,
    input logic        fifo_empty,
    input logic        rx_err_irq,
    input logic        push,
    input logic        flush_bit
);
    AST_CTRL_WRITE_SEEN: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == 2'd0) |=> (reg_addr != 2'd0 || reg_rdata[3:0] == $past(reg_wdata[3:0]))); // R1

    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == 2'd0 && reg_wdata[4]) |=> fifo_empty); // R8

    AST_FLUSH_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && reg_addr == 2'd0 && !(reg_wr && reg_addr == 2'd0 && reg_wdata[4])) |=> !flush_bit); // R8

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        (rx_err_irq && !(reg_wr && reg_addr == 2'd3 && reg_wdata[0])) |=> rx_err_irq); // R7

    AST_ERR_EMPTIES_FIFO: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_err_irq) |-> fifo_empty); // R6

    AST_NO_PUSH_IDLE: assert property (@(posedge clk) disable iff (rst)
        !rx_valid |-> !push); // R9
endmodule

bind rx_frame_filter rxf_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .reg_addr   (reg_addr),
    .reg_wr     (reg_wr),
    .reg_rd     (reg_rd),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .rx_valid   (rx_valid),
    .fifo_empty (fifo_empty),
    .rx_err_irq (rx_err_irq),
    .push       (w_cmd.push),
    .flush_bit  (w_ctrl.flush)
);

// File: tb/tb_rx_frame_filter.sv
module tb_rx_frame_filter;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  reg_addr = '0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        rx_valid = 1'b0, rx_last = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        fifo_rd = 1'b0;
    logic [7:0]  fifo_data;
    logic        fifo_empty, rx_err_irq;

    always #5 clk = ~clk;

    rx_frame_filter dut (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rx_valid(rx_valid),
        .rx_data(rx_data), .rx_last(rx_last), .fifo_rd(fifo_rd), .fifo_data(fifo_data),
        .fifo_empty(fifo_empty), .rx_err_irq(rx_err_irq)
    );

    localparam logic [47:0] STA = 48'h5544_3322_1102;

    logic [7:0] exp_q[$];
    int    n_tests = 0, n_fail = 0;
    string cur_req = "R9";
    bit    mon_en = 1'b0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Monitor: pops committed bytes and compares them with the scoreboard.
    initial begin
        forever begin
            @(negedge clk);
            if (mon_en && !rst && !fifo_empty) begin
                if (exp_q.size() == 0)
                    check(1'b0, cur_req, "unexpected byte", {24'd0, fifo_data}, 32'd0);
                else begin
                    logic [7:0] e;
                    e = exp_q.pop_front();
                    check(fifo_data == e, cur_req, "fifo byte", {24'd0, fifo_data}, {24'd0, e});
                end
                fifo_rd = 1'b1;
            end else
                fifo_rd = 1'b0;
        end
    end

    task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    function automatic logic [31:0] tb_crc(input logic [7:0] b[$]);
        logic [31:0] c;
        c = 32'hFFFFFFFF;
        foreach (b[k]) begin
            for (int j = 0; j < 8; j++) begin
                logic fb;
                fb = c[0] ^ b[k][j];
                c = c >> 1;
                if (fb) c = c ^ 32'hEDB88320;
            end
        end
        return c;
    endfunction

    // trunc > 0 cuts the frame to that many bytes.
    task automatic send_frame(input logic [47:0] da, input int plen, input bit bad,
                              input bit expect_keep, input bit hold_chk, input int trunc);
        logic [7:0]  f[$];
        logic [31:0] fcs;
        for (int i = 0; i < 6; i++) f.push_back(da[8*i +: 8]);
        for (int i = 0; i < 6; i++) f.push_back(8'hA0 + 8'(i));
        for (int i = 0; i < plen; i++) f.push_back(8'(i * 7 + plen));
        fcs = ~tb_crc(f);
        if (bad) fcs = fcs ^ 32'h0000_0100;
        for (int i = 0; i < 4; i++) f.push_back(fcs[8*i +: 8]);
        if (trunc > 0) while (f.size() > trunc) void'(f.pop_back());
        if (expect_keep) foreach (f[k]) exp_q.push_back(f[k]);
        for (int i = 0; i < f.size(); i++) begin
            @(negedge clk);
            if (hold_chk)
                check(fifo_empty == 1'b1, "R9", "fifo visible mid-frame", {31'd0, fifo_empty}, 32'd1);
            rx_valid = 1'b1; rx_data = f[i]; rx_last = (i == f.size() - 1);
        end
        @(negedge clk);
        rx_valid = 1'b0; rx_last = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic settle(input string req);
        repeat (100) @(negedge clk);
        check(exp_q.size() == 0, req, "bytes still expected", exp_q.size(), 32'd0);
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        reg_read(2'd0, rd); check(rd == 0, "R1", "ctrl reset", rd, 0);
        reg_read(2'd1, rd); check(rd == 0, "R1", "station lo reset", rd, 0);
        reg_read(2'd3, rd); check(rd == 0, "R1", "status reset", rd, 0);
        check(fifo_empty == 1'b1, "R1", "fifo empty at reset", {31'd0, fifo_empty}, 1);
        check(rx_err_irq == 1'b0, "R1", "irq at reset", {31'd0, rx_err_irq}, 0);

        // R1 programming and readback
        reg_write(2'd1, STA[31:0]);
        reg_write(2'd2, 32'hFFFF_0000 | {16'd0, STA[47:32]});
        reg_read(2'd1, rd); check(rd == STA[31:0], "R1", "station lo", rd, STA[31:0]);
        reg_read(2'd2, rd); check(rd == {16'd0, STA[47:32]}, "R1", "station hi", rd, {16'd0, STA[47:32]});
        reg_write(2'd0, 32'hFFFF_FFC9);
        reg_read(2'd0, rd); check(rd == 32'h9, "R1", "ctrl readback", rd, 32'h9);
        mon_en = 1'b1;

        // R2 receiver off
        cur_req = "R2";
        reg_write(2'd0, 32'h8);
        send_frame(STA, 10, 1'b0, 1'b0, 1'b0, 0);
        send_frame(STA, 10, 1'b1, 1'b0, 1'b0, 0);
        settle("R2");
        check(fifo_empty == 1'b1, "R2", "fifo after disabled frames", {31'd0, fifo_empty}, 1);
        check(rx_err_irq == 1'b0, "R2", "irq after disabled bad frame", {31'd0, rx_err_irq}, 0);

        // R3 unicast match and mismatch; R9 hold-off and rollback
        cur_req = "R3";
        reg_write(2'd0, 32'h9);
        send_frame(STA, 12, 1'b0, 1'b1, 1'b1, 0);
        settle("R3");
        send_frame(48'h5644_3322_1102, 12, 1'b0, 1'b0, 1'b0, 0);
        send_frame(48'h5544_3322_1103 ^ 48'h1, 12, 1'b0, 1'b1, 1'b0, 0);
        settle("R3");
        cur_req = "R9";
        send_frame(48'h5544_3322_1112, 20, 1'b0, 1'b0, 1'b0, 0);
        send_frame(STA, 9, 1'b0, 1'b1, 1'b0, 0);
        settle("R9");

        // R4 multicast gate
        cur_req = "R4";
        send_frame(48'h0000_005E_0001, 8, 1'b0, 1'b0, 1'b0, 0);
        settle("R4");
        check(fifo_empty == 1'b1, "R4", "multicast with gate off", {31'd0, fifo_empty}, 1);
        reg_write(2'd0, 32'hB);
        send_frame(48'h0000_005E_0001, 8, 1'b0, 1'b1, 1'b0, 0);
        send_frame(48'hFFFF_FFFF_FFFF, 8, 1'b0, 1'b1, 1'b0, 0);
        settle("R4");

        // R5 promiscuous
        cur_req = "R5";
        reg_write(2'd0, 32'hD);
        send_frame(48'h1234_5678_9A00, 14, 1'b0, 1'b1, 1'b0, 0);
        send_frame(48'h0000_0000_0007, 14, 1'b0, 1'b1, 1'b0, 0);
        settle("R5");

        // R6 bad CRC kept when rejection is off
        cur_req = "R6";
        reg_write(2'd0, 32'h1);
        send_frame(STA, 10, 1'b1, 1'b1, 1'b0, 0);
        settle("R6");
        check(rx_err_irq == 1'b0, "R6", "irq with rejection off", {31'd0, rx_err_irq}, 0);

        // R6 bad CRC with rejection wipes the FIFO
        reg_write(2'd0, 32'h9);
        mon_en = 1'b0;
        send_frame(STA, 10, 1'b0, 1'b0, 1'b0, 0);   // kept, then wiped by the error
        check(fifo_empty == 1'b0, "R6", "good frame held", {31'd0, fifo_empty}, 0);
        send_frame(STA, 10, 1'b1, 1'b0, 1'b0, 0);
        check(fifo_empty == 1'b1, "R6", "fifo wiped by bad crc", {31'd0, fifo_empty}, 1);
        check(rx_err_irq == 1'b1, "R6", "error flag set", {31'd0, rx_err_irq}, 1);
        mon_en = 1'b1;

        // R7 sticky flag
        cur_req = "R7";
        send_frame(STA, 10, 1'b0, 1'b1, 1'b0, 0);
        settle("R7");
        check(rx_err_irq == 1'b1, "R7", "flag kept after good frame", {31'd0, rx_err_irq}, 1);
        reg_write(2'd3, 32'h0);
        check(rx_err_irq == 1'b1, "R7", "write 0 ignored", {31'd0, rx_err_irq}, 1);
        reg_write(2'd3, 32'h1);
        check(rx_err_irq == 1'b0, "R7", "write 1 clears", {31'd0, rx_err_irq}, 0);

        // R8 flush
        cur_req = "R8";
        mon_en = 1'b0;
        send_frame(STA, 10, 1'b0, 1'b0, 1'b0, 0);   // kept, then flushed
        check(fifo_empty == 1'b0, "R8", "frame held before flush", {31'd0, fifo_empty}, 0);
        reg_write(2'd0, 32'h8);
        reg_write(2'd0, 32'h18);
        check(fifo_empty == 1'b1, "R8", "fifo after flush", {31'd0, fifo_empty}, 1);
        reg_read(2'd0, rd); check(rd == 32'h18, "R8", "flush bit reads 1", rd, 32'h18);
        reg_read(2'd0, rd); check(rd == 32'h08, "R8", "flush bit self-cleared", rd, 32'h08);
        mon_en = 1'b1;
        reg_write(2'd0, 32'h9);

        // R10 runt and overflow
        cur_req = "R10";
        send_frame(STA, 10, 1'b0, 1'b0, 1'b0, 4);
        send_frame(STA, 70, 1'b0, 1'b0, 1'b0, 0);
        settle("R10");
        check(fifo_empty == 1'b1, "R10", "runt and oversize dropped", {31'd0, fifo_empty}, 1);
        send_frame(STA, 16, 1'b0, 1'b1, 1'b0, 0);
        settle("R10");

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule